// File: doc/BRIEF.md
# I2C Target Interface with General Call

This block is the receive and transmit engine of an I2C target. It samples the bus clock and data lines with a fast system clock and cleans both lines before it looks for edges. It recognises START, repeated START and STOP. It compares the first byte of each transfer against a fixed 7-bit address set by a parameter. Both bus lines are open drain: the block never drives a line high. It only asserts an output enable that pulls the line low.

On a write, each received byte is handed to the user logic with a one-cycle strobe. A flag tells the user whether the byte came under the all-zero general call or under the block's own address. On a read, the block requests a byte from the user logic and holds the clock low until the byte arrives. It then shifts the byte out MSB first and checks the master's acknowledge to decide whether to request another byte.

A START or repeated START puts the logic back into the address phase at once, from any state. A STOP returns the block to idle with both lines released.

Top module: `i2c_gc_target`

## Requirements
- R1: A START or repeated START, detected in any state (including mid-byte), releases both line enables and restarts address reception, so the next 8 bits are taken as a fresh address byte.
- R2: An address byte whose upper 7 bits (first 7 received, MSB first) equal OWN_ADDR is acknowledged by pulling SDA low during the ninth clock, whether bit 0 (the direction bit, 1 = read) is 0 or 1.
- R3: The address byte 0x00 (address 0, write) is acknowledged. Bytes written after it are presented with wr_gc_o = 1; bytes written after an own-address write are presented with wr_gc_o = 0.
- R4: Any other address byte is not acknowledged: 0x01 (address 0 with read), reserved codes such as 0x03 and 0xF8, and foreign addresses. The block then leaves SDA and SCL released and delivers nothing until the next START.
- R5: In a write, each received byte appears on wr_data_o MSB first with a single-cycle wr_valid_o pulse, and SDA is pulled low for the acknowledge clock that follows.
- R6: In a read, after each acknowledge clock the block raises rd_req_o and holds SCL low until rd_valid_i is seen. It then releases SCL and drives rd_data_i MSB first, pulling SDA low only for 0 bits.
- R7: A not-acknowledge (SDA high) from the master after a read byte makes the block release SDA and stop requesting bytes.
- R8: An acknowledge (SDA low) from the master after a read byte makes the block request the next byte.
- R9: A STOP (SDA rising while SCL high) returns the block to idle. Clock pulses that follow without a START are ignored and are not acknowledged.
- R10: A line pulse shorter than FILT_LEN system clocks after synchronisation does not change the filtered line and does not disturb a transfer.
- R11: The block changes its SDA enable only while the filtered SCL is low, except for the release forced by START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as sensed at the pin |
| sda_i | input | 1 | Bus data line as sensed at the pin |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge or 0 data bit) |
| wr_data_o | output | 8 | Last byte written by the master |
| wr_valid_o | output | 1 | One-cycle strobe for wr_data_o |
| wr_gc_o | output | 1 | Byte in wr_data_o belongs to a general call |
| rd_req_o | output | 1 | Request for the next read byte |
| rd_data_i | input | 8 | Read byte from user logic |
| rd_valid_i | input | 1 | rd_data_i is valid; ends the stretch |

## Verification
The in-RTL assertions check, on every cycle, the rules that need no knowledge of a whole transfer. The filtered line only takes a value that the synchroniser has held. SDA enable changes happen only with SCL low. A pending read request always comes with SCL held. The write strobe lasts one cycle. A START or STOP releases both lines on the next cycle. An acknowledged address always matched the own address or the general call. The bench scenarios are what show the address decisions at the bus and the byte values and general-call flag delivered. They also show the master acknowledge deciding whether another byte is requested, the recovery from a repeated START mid-byte, the ignoring of clocks after STOP, and a short glitch on SCL passing without harm.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK,
    ST_RD_WAIT, ST_RD, ST_RD_ACK, ST_SKIP
  } tgt_state_e;

  // general call: address zero with write direction only
  function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction
endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      q_q    <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], d_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (&hist_q)       q_q <= 1'b1;
      else if (~|hist_q) q_q <= 1'b0;
    end
  end

  assign q_o = q_q;

  assert_filter_agree_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q != $past(q_q)) |-> ($past(hist_q[0]) == q_q));
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_f_i,
  input  logic              sda_f_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  output logic              wr_gc_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              rd_valid_i
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  tgt_state_e        st_q;
  logic [BYTE_W-1:0] sh_q, wr_data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sda_oe_q, scl_oe_q, wr_valid_q, wr_gc_q;
  logic              rw_q, gc_q, mack_q;
  logic              own_hit, gc_hit;

  assign own_hit = sh_q[BYTE_W-1:1] == OWN_ADDR;
  assign gc_hit  = is_gcall(sh_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sh_q       <= '0;
      wr_data_q  <= '0;
      cnt_q      <= '0;
      sda_oe_q   <= 1'b0;
      scl_oe_q   <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_gc_q    <= 1'b0;
      rw_q       <= 1'b0;
      gc_q       <= 1'b0;
      mack_q     <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
        scl_oe_q <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
        scl_oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (own_hit || gc_hit) begin
                  st_q     <= ST_ADDR_ACK;
                  sda_oe_q <= 1'b1;
                  rw_q     <= sh_q[0];
                  gc_q     <= gc_hit;
                end else begin
                  st_q <= ST_SKIP;
                end
              end else begin
                wr_data_q  <= sh_q;
                wr_valid_q <= 1'b1;
                wr_gc_q    <= gc_q;
                sda_oe_q   <= 1'b1;
                st_q       <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            sda_oe_q <= 1'b0;
            if (rw_q) begin
              st_q     <= ST_RD_WAIT;
              scl_oe_q <= 1'b1;
            end else begin
              st_q <= ST_WR;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            sda_oe_q <= 1'b0;
            st_q     <= ST_WR;
          end
          ST_RD_WAIT: if (rd_valid_i) begin
            sh_q     <= rd_data_i;
            sda_oe_q <= ~rd_data_i[BYTE_W-1];
            scl_oe_q <= 1'b0;
            cnt_q    <= '0;
            st_q     <= ST_RD;
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              sda_oe_q <= 1'b0;
              st_q     <= ST_RD_ACK;
            end else begin
              sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~sh_q[BYTE_W-2];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) mack_q <= ~sda_f_i;
            else if (scl_fall_i) begin
              if (mack_q) begin
                st_q     <= ST_RD_WAIT;
                scl_oe_q <= 1'b1;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign wr_data_o  = wr_data_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_gc_o    = wr_gc_q;
  assign rd_req_o   = st_q == ST_RD_WAIT;

  assert_restart_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!sda_oe_q && !scl_oe_q && st_q == ST_ADDR));
  assert_addr_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR_ACK && $past(st_q) == ST_ADDR) |->
      (sh_q[BYTE_W-1:1] == OWN_ADDR || sh_q == '0));
  assert_skip_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> (!sda_oe_q && !scl_oe_q));
  assert_wr_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |=> !wr_valid_q);
  assert_stretch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> scl_oe_q);
  assert_stop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE && !sda_oe_q && !scl_oe_q));
  assert_sda_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) |-> (!$past(scl_f_i) || $past(start_i || stop_i)));
endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h42,
  parameter int                SYNC_LEN = 2,
  parameter int                FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  output logic              wr_gc_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              rd_valid_i
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_tgt_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_f[g])
    );
  end

  i2c_tgt_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (line_f[0]),
    .sda_i     (line_f[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_tgt_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (line_f[0]),
    .sda_f_i   (line_f[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .wr_data_o (wr_data_o),
    .wr_valid_o(wr_valid_o),
    .wr_gc_o   (wr_gc_o),
    .rd_req_o  (rd_req_o),
    .rd_data_i (rd_data_i),
    .rd_valid_i(rd_valid_i)
  );
endmodule

// File: tb/sim_i2c_gc_target.sv
module sim_i2c_gc_target;
  localparam logic [6:0] OWN = 7'h42;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic scl_oe, sda_oe, wr_valid, wr_gc, rd_req, rd_valid = 1'b0;
  logic [7:0] wr_data, rd_data = 8'h00;
  wire scl_bus = !(m_scl_lo || scl_oe);
  wire sda_bus = !(m_sda_lo || sda_oe);

  int checks = 0, failures = 0;
  int n_wr = 0, rd_reqs = 0, rd_idx = 0;
  logic [7:0] got_data [16];
  logic       got_gc   [16];
  logic [7:0] rd_src   [4] = '{8'hC3, 8'h5E, 8'hFF, 8'h00};
  bit done = 0;

  i2c_gc_target #(.OWN_ADDR(OWN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .wr_data_o(wr_data),
    .wr_valid_o(wr_valid), .wr_gc_o(wr_gc), .rd_req_o(rd_req),
    .rd_data_i(rd_data), .rd_valid_i(rd_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (wr_valid) begin
    got_data[n_wr % 16] = wr_data;
    got_gc[n_wr % 16]   = wr_gc;
    n_wr++;
  end

  // read-data responder: checks the stretch, then answers late
  initial forever begin
    @(negedge clk);
    if (rd_req) begin
      rd_reqs++;
      repeat (30) @(negedge clk);
      chk("R6 scl held low while request pending", {31'd0, scl_bus}, 32'd0);
      rd_data  = rd_src[rd_idx % 4];
      rd_valid = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0;
      rd_idx++;
      @(negedge clk);
      chk("R6 scl released after data", {31'd0, scl_oe}, 32'd0);
    end
  end

  task automatic wait_q(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start;
    m_sda_lo = 1'b0; wait_q(Q);
    m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wait_q(Q);
    m_sda_lo = 1'b1; wait_q(Q);
    m_scl_lo = 1'b1; wait_q(Q);
  endtask

  task automatic m_stop;
    m_sda_lo = 1'b1; wait_q(Q);
    m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wait_q(Q);
    m_sda_lo = 1'b0; wait_q(Q);
  endtask

  task automatic m_bit_wr(input logic b, input bit glitch);
    m_sda_lo = !b; wait_q(Q / 2);
    if (glitch) begin
      m_scl_lo = 1'b0; wait_q(2); m_scl_lo = 1'b1;
    end
    wait_q(Q / 2);
    m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wait_q(2 * Q);
    m_scl_lo = 1'b1; wait_q(Q);
  endtask

  task automatic m_bit_rd(output logic b);
    m_sda_lo = 1'b0; wait_q(Q);
    m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wait_q(Q);
    b = sda_bus;
    wait_q(Q);
    m_scl_lo = 1'b1; wait_q(Q);
  endtask

  task automatic m_byte_wr(input logic [7:0] v, input bit glitch, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_wr(v[i], glitch && i == 4);
    m_bit_rd(b);
    acked = !b;
  endtask

  task automatic m_byte_rd(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_rd(b);
      v[i] = b;
    end
    m_bit_wr(!ack, 1'b0);
  endtask

  task automatic t_reset;
    chk("R9 reset scl_oe", {31'd0, scl_oe}, 0);
    chk("R9 reset sda_oe", {31'd0, sda_oe}, 0);
    chk("R5 reset wr_valid", {31'd0, wr_valid}, 0);
    chk("R6 reset rd_req", {31'd0, rd_req}, 0);
  endtask

  task automatic t_own_write;
    logic a; int n0 = n_wr;
    m_start;
    m_byte_wr({OWN, 1'b0}, 0, a); chk("R2 own write addr ack", {31'd0, a}, 1);
    m_byte_wr(8'hA5, 0, a);       chk("R5 ack byte0", {31'd0, a}, 1);
    m_byte_wr(8'h3C, 0, a);       chk("R5 ack byte1", {31'd0, a}, 1);
    m_stop;
    chk("R5 write count", n_wr - n0, 2);
    chk("R5 byte0 value", {24'd0, got_data[n0 % 16]}, 32'hA5);
    chk("R5 byte1 value", {24'd0, got_data[(n0 + 1) % 16]}, 32'h3C);
    chk("R3 own data not gc", {31'd0, got_gc[n0 % 16]}, 0);
  endtask

  task automatic t_gcall;
    logic a; int n0 = n_wr;
    m_start;
    m_byte_wr(8'h00, 0, a); chk("R3 gcall ack", {31'd0, a}, 1);
    m_byte_wr(8'h5A, 0, a); chk("R3 gcall data ack", {31'd0, a}, 1);
    m_stop;
    chk("R3 gcall count", n_wr - n0, 1);
    chk("R3 gcall value", {24'd0, got_data[n0 % 16]}, 32'h5A);
    chk("R3 gcall flag", {31'd0, got_gc[n0 % 16]}, 1);
  endtask

  task automatic t_reject(input logic [7:0] ab, input string tag);
    logic a; int n0 = n_wr, r0 = rd_reqs;
    m_start;
    m_byte_wr(ab, 0, a);    chk({"R4 no ack ", tag}, {31'd0, a}, 0);
    m_byte_wr(8'h99, 0, a); chk({"R4 no data ack ", tag}, {31'd0, a}, 0);
    m_stop;
    chk({"R4 nothing delivered ", tag}, n_wr - n0, 0);
    chk({"R4 no request ", tag}, rd_reqs - r0, 0);
  endtask

  task automatic t_read;
    logic a; logic [7:0] v; int r0 = rd_reqs, i0 = rd_idx;
    m_start;
    m_byte_wr({OWN, 1'b1}, 0, a); chk("R2 own read addr ack", {31'd0, a}, 1);
    m_byte_rd(1'b1, v); chk("R6 read byte0", {24'd0, v}, {24'd0, rd_src[i0 % 4]});
    m_byte_rd(1'b0, v); chk("R8 read byte1 after ack", {24'd0, v}, {24'd0, rd_src[(i0 + 1) % 4]});
    wait_q(4 * Q);
    chk("R7 sda released after nack", {31'd0, sda_oe}, 0);
    chk("R7 scl released after nack", {31'd0, scl_oe}, 0);
    m_stop;
    chk("R7 R8 request count", rd_reqs - r0, 2);
  endtask

  task automatic t_restart;
    logic a; int n0 = n_wr;
    m_start;
    m_byte_wr({OWN, 1'b0}, 0, a); chk("R1 first addr ack", {31'd0, a}, 1);
    for (int i = 0; i < 3; i++) m_bit_wr(1'b1, 0);
    m_start;
    m_byte_wr({OWN, 1'b0}, 0, a); chk("R1 addr ack after restart", {31'd0, a}, 1);
    m_byte_wr(8'h77, 0, a);
    m_stop;
    chk("R1 one byte only", n_wr - n0, 1);
    chk("R1 byte value", {24'd0, got_data[n0 % 16]}, 32'h77);
  endtask

  task automatic t_glitch;
    logic a; int n0 = n_wr;
    m_start;
    m_byte_wr({OWN, 1'b0}, 0, a);
    m_byte_wr(8'hD2, 1, a); chk("R10 ack with glitch", {31'd0, a}, 1);
    m_stop;
    chk("R10 glitch byte value", {24'd0, got_data[n0 % 16]}, 32'hD2);
  endtask

  task automatic t_after_stop;
    logic a; int n0 = n_wr;
    m_byte_wr({OWN, 1'b0}, 0, a); chk("R9 no ack without start", {31'd0, a}, 0);
    m_byte_wr(8'h11, 0, a);
    chk("R9 nothing delivered", n_wr - n0, 0);
    m_sda_lo = 1'b0; wait_q(Q);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_own_write;
    t_gcall;
    t_reject(8'h01, "gcall read");
    t_reject(8'h03, "reserved 0000001");
    t_reject(8'hF8, "reserved 11111");
    t_reject(8'h66, "foreign");
    t_read;
    t_restart;
    t_glitch;
    t_after_stop;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule